// File: doc/BRIEF.md
# Frame-Checked Serial Command Slave

This block is the command port of a safety-critical actuator controller. A host drives a byte-wide synchronous serial link into it. A frame is open while chip select is high. During each frame the block shifts one 8-bit command in and one 8-bit response out at the same time, most significant bit first. All three serial pins pass through two-flop synchronizers into a faster system clock, and every serial event is detected on edges there. The serial clock may run at up to 2 MHz.

The block counts serial clock rising edges in every frame. A frame with exactly eight of them is valid. A frame with any other count is rejected: its command is discarded, and the next valid frame returns an error byte. A valid command does one of two things. It either asks for a status or fault snapshot in the next frame, or it writes its low nibble into one of five 4-bit control registers. The response sent in a frame therefore depends on the frame before it. That response is the error byte, the requested snapshot, or an echo of the byte last received.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, every control register reads 0, `sdoOut` is 0, and the first valid frame returns 0x00.
- R2: Both directions are MSB first. `sdiIn` is taken on each rising edge of `sclkIn`. The next response bit appears on `sdoOut` before the following rising edge, and the first bit appears before the first rising edge.
- R3: A frame runs from a rise of `csIn` to its fall. It is valid only when it contains exactly 8 rising edges of `sclkIn`. Any other count, zero included, is a frame error.
- R4: A frame that has a frame error writes no register. It also leaves unchanged the response chosen for the next frame and the byte held for echo.
- R5: The first valid frame after one or more frame errors returns 0xFE. The error condition then clears. The frame after that returns whatever the command carried in the 0xFE frame selected.
- R6: After a valid frame whose upper nibble is neither 0x1 nor 0x2, the next frame returns that whole received byte.
- R7: After a valid command with upper nibble 0x1, the next frame returns a status byte. Bits 7:6 are 0. Bits 5 to 0 carry `statusIn[5:0]`: path 1 active, path 2 active, safing switch closed, reserve supply low, battery low, charge pump low.
- R8: After a valid command with upper nibble 0x2, the next frame returns a fault byte. Bits 7:4 are 0. Bits 3 to 0 carry `faultIn[3:0]`: path 2 high side high, path 1 high side high, path 2 low side low, path 1 low side low.
- R9: At the end of a valid frame, the low nibble is written into one register chosen by the upper nibble: 0x3 to `resMeasSel`, 0x4 to `muxSel`, 0x5 to `lowSideCtl`, 0x6 to `auxCtl`, 0xA to `highSideCtl`. The other four registers hold.
- R10: Upper nibbles 0x0, 0x7, 0x8, 0x9 and 0xB to 0xF change no register.
- R11: The status and fault inputs are captured when `csIn` rises. Changes to them later in the same frame do not alter that frame's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select; the frame is open while high |
| sclkIn | input | 1 | Serial clock from the host |
| sdiIn | input | 1 | Serial command data in |
| sdoOut | output | 1 | Serial response data out |
| statusIn | input | 6 | Live status flags (R7 mapping) |
| faultIn | input | 4 | Live fault flags (R8 mapping) |
| resMeasSel | output | 4 | Resistance-measurement select register |
| muxSel | output | 4 | Analog multiplexer select register |
| lowSideCtl | output | 4 | Low-side switch control register |
| auxCtl | output | 4 | Auxiliary control register |
| highSideCtl | output | 4 | High-side switch control register |

## Verification
The bench sends frames with 0, 7 and 9 clocks. A design that miscounted these would accept a short or long frame and write a register from half a command. It also checks that 0xFE comes out exactly once after two errors in a row, and that the frame after the 0xFE frame returns what that frame's command selected. A design that cleared or chained the error flag wrongly would repeat the error byte or lose a status read. Every unlisted opcode is swept while all five registers are compared on every clock. The status inputs are changed in the middle of a read frame, which catches a snapshot that is not captured when chip select rises.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam int NUM_CTRL = 5;
  localparam int NIB_W    = 4;

  localparam int REG_RES  = 0;
  localparam int REG_MUX  = 1;
  localparam int REG_LOW  = 2;
  localparam int REG_AUX  = 3;
  localparam int REG_HIGH = 4;

  localparam logic [3:0] OP_RD_STAT = 4'h1;
  localparam logic [3:0] OP_RD_FLT  = 4'h2;
  localparam logic [3:0] OP_RES     = 4'h3;
  localparam logic [3:0] OP_MUX     = 4'h4;
  localparam logic [3:0] OP_LOW     = 4'h5;
  localparam logic [3:0] OP_AUX     = 4'h6;
  localparam logic [3:0] OP_HIGH    = 4'hA;

  localparam logic [7:0] ERR_BYTE = 8'hFE;

  typedef enum logic [1:0] {
    SEL_ECHO  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_FAULT = 2'd2,
    SEL_ERR   = 2'd3
  } respSel_e;

  typedef struct packed {
    logic                loadTx;
    logic                shiftBit;
    logic                commit;
    respSel_e            txSel;
    logic [NUM_CTRL-1:0] wrEn;
  } dpStrobes_t;

endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csHigh,
  input  logic                  csRise,
  input  logic                  csFall,
  input  logic                  sclkRise,
  input  logic [FRAME_BITS-1:0] rxByte,
  output dpStrobes_t            str
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] bitCnt;
  logic             frameOpen;
  logic             errPending;
  logic             errSent;
  respSel_e         respSelQ;
  respSel_e         nextSel;
  logic [3:0]       opcode;
  logic [NUM_CTRL-1:0] decWr;

  assign opcode = rxByte[FRAME_BITS-1 -: 4];

  always_comb begin
    decWr   = '0;
    nextSel = SEL_ECHO;
    case (opcode)
      OP_RD_STAT: nextSel = SEL_STAT;
      OP_RD_FLT:  nextSel = SEL_FAULT;
      OP_RES:     decWr[REG_RES]  = 1'b1;
      OP_MUX:     decWr[REG_MUX]  = 1'b1;
      OP_LOW:     decWr[REG_LOW]  = 1'b1;
      OP_AUX:     decWr[REG_AUX]  = 1'b1;
      OP_HIGH:    decWr[REG_HIGH] = 1'b1;
      default:    ;
    endcase
  end

  always_comb begin
    str.loadTx   = csRise;
    str.shiftBit = sclkRise && csHigh && frameOpen;
    str.commit   = csFall && frameOpen && (bitCnt == CNT_GOOD);
    str.txSel    = errPending ? SEL_ERR : respSelQ;
    str.wrEn     = str.commit ? decWr : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      frameOpen  <= 1'b0;
      errPending <= 1'b0;
      errSent    <= 1'b0;
      respSelQ   <= SEL_ECHO;
    end else begin
      if (csRise) begin
        bitCnt    <= '0;
        frameOpen <= 1'b1;
        errSent   <= errPending;
      end else if (str.shiftBit) begin
        if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
      end
      if (csFall && frameOpen) begin
        frameOpen <= 1'b0;
        if (str.commit) begin
          respSelQ <= nextSel;
          if (errSent) errPending <= 1'b0;
        end else begin
          errPending <= 1'b1;
        end
      end
    end
  end

  // R3: within a frame the edge count never goes backwards
  p_count_mono_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!csRise) |=> (bitCnt >= $past(bitCnt)));

  // R5: a good frame that carried the error byte leaves no error pending
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (str.commit && errSent) |=> !errPending);

endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csIn,
  input  logic                  sclkIn,
  input  logic                  sdiIn,
  input  logic [5:0]            statusIn,
  input  logic [3:0]            faultIn,
  input  dpStrobes_t            str,
  output logic                  csHigh,
  output logic                  csRise,
  output logic                  csFall,
  output logic                  sclkRise,
  output logic [FRAME_BITS-1:0] rxByte,
  output logic                  sdoOut,
  output logic [NIB_W-1:0]      ctrlReg [NUM_CTRL]
);

  logic [2:0] pinSync;
  logic       csPrev;
  logic       sclkPrev;
  logic       sdiS;
  logic       sclkS;
  logic [FRAME_BITS-1:0] rxShift;
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] lastRx;
  logic [FRAME_BITS-1:0] txLoadVal;

  sfs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({csIn, sclkIn, sdiIn}),
    .syncOut (pinSync)
  );

  assign csHigh = pinSync[2];
  assign sclkS  = pinSync[1];
  assign sdiS   = pinSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csHigh;
      sclkPrev <= sclkS;
    end
  end

  assign csRise   = csHigh && !csPrev;
  assign csFall   = !csHigh && csPrev;
  assign sclkRise = sclkS && !sclkPrev;

  always_comb begin
    case (str.txSel)
      SEL_STAT:  txLoadVal = FRAME_BITS'({2'b00, statusIn});
      SEL_FAULT: txLoadVal = FRAME_BITS'({4'b0000, faultIn});
      SEL_ERR:   txLoadVal = FRAME_BITS'(ERR_BYTE);
      default:   txLoadVal = lastRx;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      lastRx  <= '0;
    end else begin
      if (str.shiftBit) rxShift <= {rxShift[FRAME_BITS-2:0], sdiS};
      if (str.loadTx)        txShift <= txLoadVal;
      else if (str.shiftBit) txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      if (str.commit) lastRx <= rxShift;
    end
  end

  assign rxByte = rxShift;
  assign sdoOut = txShift[FRAME_BITS-1];

  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             ctrlReg[i] <= '0;
        else if (str.wrEn[i])  ctrlReg[i] <= rxShift[NIB_W-1:0];
      end

      // R10: a register moves only when its own write strobe fired
      p_reg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
        (!str.wrEn[i]) |=> $stable(ctrlReg[i]));
    end
  endgenerate

  // R9: at most one register is written per committed frame
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str.wrEn));

  // R2: the transmit bits move only on a load or a serial clock edge
  p_tx_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!str.loadTx && !str.shiftBit) |=> $stable(txShift));

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import sfs_pkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       sclkIn,
  input  logic       sdiIn,
  output logic       sdoOut,
  input  logic [5:0] statusIn,
  input  logic [3:0] faultIn,
  output logic [3:0] resMeasSel,
  output logic [3:0] muxSel,
  output logic [3:0] lowSideCtl,
  output logic [3:0] auxCtl,
  output logic [3:0] highSideCtl
);

  dpStrobes_t            str;
  logic                  csHigh;
  logic                  csRise;
  logic                  csFall;
  logic                  sclkRise;
  logic [FRAME_BITS-1:0] rxByte;
  logic [NIB_W-1:0]      ctrlReg [NUM_CTRL];

  sfs_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csHigh   (csHigh),
    .csRise   (csRise),
    .csFall   (csFall),
    .sclkRise (sclkRise),
    .rxByte   (rxByte),
    .str      (str)
  );

  sfs_datapath #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .csIn     (csIn),
    .sclkIn   (sclkIn),
    .sdiIn    (sdiIn),
    .statusIn (statusIn),
    .faultIn  (faultIn),
    .str      (str),
    .csHigh   (csHigh),
    .csRise   (csRise),
    .csFall   (csFall),
    .sclkRise (sclkRise),
    .rxByte   (rxByte),
    .sdoOut   (sdoOut),
    .ctrlReg  (ctrlReg)
  );

  assign resMeasSel  = ctrlReg[REG_RES];
  assign muxSel      = ctrlReg[REG_MUX];
  assign lowSideCtl  = ctrlReg[REG_LOW];
  assign auxCtl      = ctrlReg[REG_AUX];
  assign highSideCtl = ctrlReg[REG_HIGH];

endmodule

// File: tb/tb_spi_frame_slave.sv
module tb_spi_frame_slave;

  localparam int HALF = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic sclkIn = 1'b0;
  logic sdiIn = 1'b0;
  logic sdoOut;
  logic [5:0] statusIn = '0;
  logic [3:0] faultIn = '0;
  logic [3:0] resMeasSel, muxSel, lowSideCtl, auxCtl, highSideCtl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit regWatch = 1'b0;
  bit busy = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int  mRegs [5];
  int  mLast = 0;
  int  mSel = 0;      // 0 echo, 1 status, 2 fault
  bit  mErr = 1'b0;

  always #10 clk = ~clk;

  spi_frame_slave dut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .sdoOut(sdoOut), .statusIn(statusIn), .faultIn(faultIn),
    .resMeasSel(resMeasSel), .muxSel(muxSel), .lowSideCtl(lowSideCtl),
    .auxCtl(auxCtl), .highSideCtl(highSideCtl)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog R1 timeout actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // register comparison on every clock (R9, R10, R4)
  always @(negedge clk) begin
    if (regWatch && !busy) begin
      checks++;
      if (resMeasSel != mRegs[0][3:0] || muxSel != mRegs[1][3:0] ||
          lowSideCtl != mRegs[2][3:0] || auxCtl != mRegs[3][3:0] ||
          highSideCtl != mRegs[4][3:0]) begin
        errors++;
        $display("FAIL R9/R10 regs actual=%h%h%h%h%h expected=%h%h%h%h%h",
                 resMeasSel, muxSel, lowSideCtl, auxCtl, highSideCtl,
                 mRegs[0][3:0], mRegs[1][3:0], mRegs[2][3:0], mRegs[3][3:0],
                 mRegs[4][3:0]);
      end
    end
  end

  function automatic logic [7:0] expResp();
    if (mErr) return 8'hFE;
    if (mSel == 1) return {2'b00, statusIn};
    if (mSel == 2) return {4'b0000, faultIn};
    return mLast[7:0];
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doFrame(input logic [7:0] cmd, input int nClk, input string tag,
                         input bit chgStat = 1'b0, input logic [5:0] newStat = '0);
    logic [7:0] got = '0;
    logic [7:0] exp;
    exp = expResp();
    csIn = 1'b1;
    waitN(HALF);
    for (int i = 0; i < nClk; i++) begin
      sdiIn = (i < 8) ? cmd[7-i] : 1'b0;
      if (chgStat && i == 4) statusIn = newStat;
      waitN(HALF);
      if (i < 8) got = {got[6:0], sdoOut};
      sclkIn = 1'b1;
      waitN(HALF);
      sclkIn = 1'b0;
    end
    waitN(HALF);
    busy = 1'b1;
    csIn = 1'b0;
    waitN(8);
    if (nClk == 8) begin
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s response actual=%h expected=%h", tag, got, exp);
      end
      if (mErr) mErr = 1'b0;
      mLast = cmd;
      case (cmd[7:4])
        4'h1: mSel = 1;
        4'h2: mSel = 2;
        default: mSel = 0;
      endcase
      case (cmd[7:4])
        4'h3: mRegs[0] = cmd[3:0];
        4'h4: mRegs[1] = cmd[3:0];
        4'h5: mRegs[2] = cmd[3:0];
        4'h6: mRegs[3] = cmd[3:0];
        4'hA: mRegs[4] = cmd[3:0];
        default: ;
      endcase
    end else begin
      mErr = 1'b1;
    end
    busy = 1'b0;
    waitN(HALF);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) mRegs[k] = 0;
    waitN(5);
    rstN = 1'b1;
    waitN(4);
    // R1: reset state
    checks++;
    if (sdoOut !== 1'b0 || {resMeasSel, muxSel, lowSideCtl, auxCtl, highSideCtl} !== 20'h0) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%h expected=0/00000", sdoOut,
               {resMeasSel, muxSel, lowSideCtl, auxCtl, highSideCtl});
    end
    regWatch = 1'b1;

    doFrame(8'h3A, 8, "R1 first frame zero, R9 res write");
    doFrame(8'h47, 8, "R6 echo, R2 msb order");
    doFrame(8'h59, 8, "R6 echo R9 low write");
    doFrame(8'h6C, 8, "R6 echo R9 aux write");
    doFrame(8'hA5, 8, "R6 echo R9 high write");

    statusIn = 6'b101101;
    doFrame(8'h1F, 8, "R6 echo before status read");
    doFrame(8'h2E, 8, "R7 status byte, R11 capture at cs rise", 1'b1, 6'b010010);
    faultIn = 4'b1010;
    doFrame(8'h00, 8, "R8 fault byte");
    faultIn = 4'b0101;
    doFrame(8'h21, 8, "R6 echo of ignored opcode 0");
    doFrame(8'h00, 8, "R8 fault byte alternate");

    // frame errors: short, long, none
    doFrame(8'h3F, 7, "R3 short frame");
    doFrame(8'h4F, 9, "R3 long frame");
    doFrame(8'h71, 8, "R5 error byte after two bad frames, R4 no write");
    doFrame(8'h00, 8, "R5 cleared, R6 echo of FE-frame command");
    doFrame(8'h55, 0, "R3 zero-clock frame");
    doFrame(8'h10, 8, "R5 error byte with status request");
    statusIn = 6'b111000;
    doFrame(8'h00, 8, "R5 R7 status selected by FE frame");

    // R10: every non-writing opcode leaves registers alone
    foreach (mRegs[k]) begin end
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op == 7 || op == 8 || op == 9 || op >= 11)
        doFrame({op[3:0], 4'h6}, 8, "R10 ignored opcode, R6 echo");
    end
    doFrame(8'h3C, 8, "R10 then R9 write after sweep");
    doFrame(8'h00, 8, "R6 echo after write");

    regWatch = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule